// File: doc/BRIEF.md
# Configurable Microcontroller Bus Front End

This block connects an external microcontroller bus to the memory and address-decode logic inside a chip. A two-bit configuration register picks the bus style and the data width. In multiplexed mode the low address word shares pins with data and is captured by an active-high address-latch strobe. The high address byte is captured the same way, and the captured low address can be driven back out on an address port. In the other style the processor supplies an enable clock and a read/write line, and the block turns them into separate read and write strobes.

All processor strobes are sampled into the internal clock domain before use. The block reports a full 24-bit decode address and separate strobes for data reads, data writes and program reads. For a 16-bit data path it also gives two byte-lane selects. A second set of address inputs passes through with no capture at all, for general decode that does not select program memory. The block also produces a processor reset that is held for a fixed number of clocks after the reset input is released, so that the processor leaves reset in step with the interface.

Top module: `mcu_bus_front`

## Requirements
- R1: The configuration register resets to non-multiplexed, 8-bit mode. It loads `cfg_mux_in` and `cfg_wide_in` on a clock edge where `cfg_wr` is high, and the new mode applies from the next edge.
- R2: In multiplexed mode the low decode address `dec_addr[15:0]` follows `ad_in` while `ale` is high, two clock edges behind the pins. From the edge after `ale` is sampled low, it holds its value even when `ad_in` changes.
- R3: The high decode address `dec_addr[23:16]` is captured from `hi_addr_in` under the same `ale` rule in multiplexed mode. In non-multiplexed mode both `dec_addr` halves follow their pins one clock edge behind, with no capture.
- R4: `aux_out` equals `aux_in` in the same cycle, with no register and no capture.
- R5: `addr_out` carries the captured low address and `addr_oe` is 1 only in multiplexed mode. In non-multiplexed mode `addr_out` is 0 and `addr_oe` is 0.
- R6: In non-multiplexed mode, `mem_rd` = `bus_e` AND `bus_rw`, and `mem_wr` = `bus_e` AND NOT `bus_rw`. Both use values sampled one edge earlier, and `rd_n` and `wr_n` are ignored.
- R7: In multiplexed mode, `mem_rd` is the inverse of the sampled `rd_n` and `mem_wr` is the inverse of the sampled `wr_n`, and `bus_e` and `bus_rw` are ignored. In both modes `prog_rd` is the inverse of the sampled `psen_n`.
- R8: The byte lanes are 0 unless one of `mem_rd`, `mem_wr` or `prog_rd` is 1. During an access in 8-bit mode `lane_lo`=1 and `lane_hi`=0. During an access in 16-bit mode `lane_lo` = NOT address bit 0 of `dec_addr`, and `lane_hi` = NOT the sampled `bhe_n`.
- R9: `rst_out_n` is 0 during reset. It stays 0 for RST_HOLD clock edges after `rst_n` is released and rises at the RST_HOLD-th edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Loads the configuration register |
| cfg_mux_in | input | 1 | Mode value to load: 1 = multiplexed |
| cfg_wide_in | input | 1 | Width value to load: 1 = 16-bit data |
| ale | input | 1 | Address-latch strobe, active high |
| ad_in | input | 16 | Low address pins (shared with data in multiplexed mode) |
| hi_addr_in | input | 8 | High address pins A16..A23 |
| aux_in | input | 8 | Address inputs passed through with no capture |
| bus_e | input | 1 | Enable clock for the enable-style bus |
| bus_rw | input | 1 | Read/write line, 1 = read |
| rd_n | input | 1 | Data read strobe, active low |
| wr_n | input | 1 | Data write strobe, active low |
| psen_n | input | 1 | Program-store enable, active low |
| bhe_n | input | 1 | Byte-high enable, active low |
| dec_addr | output | 24 | Address presented to decode logic |
| aux_out | output | 8 | Pass-through of aux_in |
| addr_out | output | 16 | Captured low address re-export |
| addr_oe | output | 1 | Output enable for addr_out |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| prog_rd | output | 1 | Program memory read strobe |
| lane_lo | output | 1 | Low data byte selected |
| lane_hi | output | 1 | High data byte selected |
| rst_out_n | output | 1 | Reset to the processor, active low |

## Verification
The embedded properties assume that the configuration register changes only on a `cfg_wr` edge. They also assume that the processor never asserts `rd_n` and `wr_n` together in multiplexed mode. The stimulus always loads the configuration first and holds every other pin steady for two edges before it samples. Each table vector drives at most one write-type strobe, so the mutual-exclusion check on the strobes never sees a combination a real processor would not produce.

// File: rtl/mcu_bus_front.sv
module mcu_bus_front #(
  parameter int LO_W     = 16,
  parameter int HI_W     = 8,
  parameter int AUX_W    = 8,
  parameter int RST_HOLD = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic                 cfg_mux_in,
  input  logic                 cfg_wide_in,
  input  logic                 ale,
  input  logic [LO_W-1:0]      ad_in,
  input  logic [HI_W-1:0]      hi_addr_in,
  input  logic [AUX_W-1:0]     aux_in,
  input  logic                 bus_e,
  input  logic                 bus_rw,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic                 psen_n,
  input  logic                 bhe_n,
  output logic [LO_W+HI_W-1:0] dec_addr,
  output logic [AUX_W-1:0]     aux_out,
  output logic [LO_W-1:0]      addr_out,
  output logic                 addr_oe,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic                 prog_rd,
  output logic                 lane_lo,
  output logic                 lane_hi,
  output logic                 rst_out_n
);

  localparam int CW = $clog2(RST_HOLD + 1);

  logic            mode_mux, mode_wide;
  logic            s_ale, s_e, s_rw, s_rd_n, s_wr_n, s_psen_n, s_bhe_n;
  logic [LO_W-1:0] s_ad, lo_lat;
  logic [HI_W-1:0] s_hi, hi_lat;
  logic [CW-1:0]   hold_cnt;
  logic [LO_W-1:0] lo_cur;
  logic [HI_W-1:0] hi_cur;
  logic            access;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_mux  <= 1'b0;
      mode_wide <= 1'b0;
    end else if (cfg_wr) begin
      mode_mux  <= cfg_mux_in;
      mode_wide <= cfg_wide_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_ale    <= 1'b0;
      s_e      <= 1'b0;
      s_rw     <= 1'b1;
      s_rd_n   <= 1'b1;
      s_wr_n   <= 1'b1;
      s_psen_n <= 1'b1;
      s_bhe_n  <= 1'b1;
      s_ad     <= '0;
      s_hi     <= '0;
    end else begin
      s_ale    <= ale;
      s_e      <= bus_e;
      s_rw     <= bus_rw;
      s_rd_n   <= rd_n;
      s_wr_n   <= wr_n;
      s_psen_n <= psen_n;
      s_bhe_n  <= bhe_n;
      s_ad     <= ad_in;
      s_hi     <= hi_addr_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_lat <= '0;
      hi_lat <= '0;
    end else if (s_ale) begin
      lo_lat <= s_ad;
      hi_lat <= s_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      hold_cnt <= '0;
    else if (hold_cnt != CW'(RST_HOLD))
      hold_cnt <= hold_cnt + 1'b1;
  end

  assign rst_out_n = (hold_cnt == CW'(RST_HOLD));

  assign lo_cur   = mode_mux ? lo_lat : s_ad;
  assign hi_cur   = mode_mux ? hi_lat : s_hi;
  assign dec_addr = {hi_cur, lo_cur};
  assign aux_out  = aux_in;

  assign addr_oe  = mode_mux;
  assign addr_out = mode_mux ? lo_lat : '0;

  assign mem_rd  = mode_mux ? ~s_rd_n : (s_e &  s_rw);
  assign mem_wr  = mode_mux ? ~s_wr_n : (s_e & ~s_rw);
  assign prog_rd = ~s_psen_n;

  assign access  = mem_rd | mem_wr | prog_rd;
  assign lane_lo = access & (mode_wide ? ~lo_cur[0] : 1'b1);
  assign lane_hi = access & mode_wide & ~s_bhe_n;

  // R2
  address_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_mux && !s_ale && !cfg_wr) |=> $stable(addr_out));

  // R5
  addr_port_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_oe |-> (addr_out == '0));

  // R6
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_mux |-> !(mem_rd && mem_wr));

  // R8
  narrow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wide |-> !lane_hi);

  // R8
  lane_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_lo || lane_hi) |-> (mem_rd || mem_wr || prog_rd));

  // R9
  reset_out_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rst_out_n);

  // R9
  reset_out_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out_n |=> rst_out_n);

endmodule

// File: tb/mcu_bus_front_test.sv
module mcu_bus_front_test;
  localparam int HOLD = 8;

  logic        clk = 1'b0;
  logic        rst_n, cfg_wr, cfg_mux_in, cfg_wide_in, ale;
  logic [15:0] ad_in;
  logic [7:0]  hi_addr_in, aux_in;
  logic        bus_e, bus_rw, rd_n, wr_n, psen_n, bhe_n;
  logic [23:0] dec_addr;
  logic [7:0]  aux_out;
  logic [15:0] addr_out;
  logic        addr_oe, mem_rd, mem_wr, prog_rd, lane_lo, lane_hi, rst_out_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  mcu_bus_front #(.RST_HOLD(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mux_in(cfg_mux_in),
    .cfg_wide_in(cfg_wide_in), .ale(ale), .ad_in(ad_in), .hi_addr_in(hi_addr_in),
    .aux_in(aux_in), .bus_e(bus_e), .bus_rw(bus_rw), .rd_n(rd_n), .wr_n(wr_n),
    .psen_n(psen_n), .bhe_n(bhe_n), .dec_addr(dec_addr), .aux_out(aux_out),
    .addr_out(addr_out), .addr_oe(addr_oe), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .prog_rd(prog_rd), .lane_lo(lane_lo), .lane_hi(lane_hi), .rst_out_n(rst_out_n));

  // {mux, wide, e, rw, rd_n, wr_n, psen_n, a0, bhe_n} -> {rd, wr, prd, lo, hi}
  localparam logic [13:0] VECS [12] = '{
    14'b00_11_111_01_10010,
    14'b00_10_111_01_01010,
    14'b00_01_001_01_00000,
    14'b01_11_111_00_10011,
    14'b01_10_111_10_01001,
    14'b01_11_111_01_10010,
    14'b10_11_011_10_10010,
    14'b10_00_101_01_01010,
    14'b11_00_110_00_00111,
    14'b11_10_111_10_00000,
    14'b11_01_011_10_10001,
    14'b00_01_110_01_00110
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input bit m, input bit w);
    cfg_mux_in = m; cfg_wide_in = w; cfg_wr = 1'b1;
    tick(1);
    cfg_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_mux_in = 1'b0; cfg_wide_in = 1'b0;
    ale = 1'b0; ad_in = '0; hi_addr_in = '0; aux_in = '0;
    bus_e = 1'b0; bus_rw = 1'b1; rd_n = 1'b1; wr_n = 1'b1; psen_n = 1'b1; bhe_n = 1'b1;
    tick(3);
    check(rst_out_n == 1'b0, "R9", rst_out_n, 0);
    check({mem_rd, mem_wr, prog_rd} == 3'b000, "R7", {mem_rd, mem_wr, prog_rd}, 0);
    check(addr_oe == 1'b0, "R1", addr_oe, 0);
    rst_n = 1'b1;
    tick(HOLD - 1);
    check(rst_out_n == 1'b0, "R9", rst_out_n, 0);
    tick(1);
    check(rst_out_n == 1'b1, "R9", rst_out_n, 1);

    for (int i = 0; i < 12; i++) begin
      logic [13:0] v;
      v = VECS[i];
      set_cfg(v[13], v[12]);
      bus_e = v[11]; bus_rw = v[10]; rd_n = v[9]; wr_n = v[8]; psen_n = v[7];
      ad_in = {15'h0, v[6]}; bhe_n = v[5]; ale = 1'b1;
      tick(2);
      check(mem_rd == v[4], v[13] ? "R7" : "R6", mem_rd, v[4]);
      check(mem_wr == v[3], v[13] ? "R7" : "R6", mem_wr, v[3]);
      check(prog_rd == v[2], "R7", prog_rd, v[2]);
      check({lane_lo, lane_hi} == v[1:0], "R8", {lane_lo, lane_hi}, v[1:0]);
      bus_e = 1'b0; rd_n = 1'b1; wr_n = 1'b1; psen_n = 1'b1; bhe_n = 1'b1; ale = 1'b0;
    end

    // R1, R2, R3, R5: capture in multiplexed mode
    set_cfg(1'b1, 1'b1);
    check(addr_oe == 1'b1, "R1", addr_oe, 1);
    ad_in = 16'hA5C3; hi_addr_in = 8'h7E; ale = 1'b1;
    tick(2);
    check(dec_addr == 24'h7EA5C3, "R2", dec_addr, 24'h7EA5C3);
    check(addr_out == 16'hA5C3, "R5", addr_out, 16'hA5C3);
    ad_in = 16'h1234; hi_addr_in = 8'h11;
    tick(2);
    check(dec_addr == 24'h111234, "R2", dec_addr, 24'h111234);
    ale = 1'b0; ad_in = 16'hBEEF; hi_addr_in = 8'h99;
    tick(1);
    check(dec_addr[15:0] == 16'h1234, "R2", dec_addr[15:0], 16'h1234);
    tick(2);
    check(dec_addr[15:0] == 16'h1234, "R2", dec_addr[15:0], 16'h1234);
    check(dec_addr[23:16] == 8'h11, "R3", dec_addr[23:16], 8'h11);
    check(addr_out == 16'h1234, "R5", addr_out, 16'h1234);

    // R3, R5: non-multiplexed follows pins, port idle
    set_cfg(1'b0, 1'b0);
    check(addr_oe == 1'b0, "R5", addr_oe, 0);
    check(addr_out == 16'h0, "R5", addr_out, 0);
    ad_in = 16'h4321; hi_addr_in = 8'h5A;
    tick(1);
    check(dec_addr == 24'h5A4321, "R3", dec_addr, 24'h5A4321);

    // R4: pass-through in the same cycle
    aux_in = 8'hC6; #1;
    check(aux_out == 8'hC6, "R4", aux_out, 8'hC6);
    aux_in = 8'h3B; #1;
    check(aux_out == 8'h3B, "R4", aux_out, 8'h3B);

    // R1: config held without cfg_wr
    cfg_mux_in = 1'b1;
    tick(2);
    check(addr_oe == 1'b0, "R1", addr_oe, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule